// File: doc/BRIEF.md
# Filter and Prescaler Cell Array

This block conditions a small set of digital input lines before they reach timers or capture logic. It holds a chain of identical cells. Each cell picks one input: a synchronised port line, a free-running toggle that changes on every module clock, or the conditioned output of the cell below it. It also picks one counting enable, either every module clock or one of several externally generated enables. Every cell works in one of three modes. As a prescaler it divides an edge stream by a programmable count. As a delayed filter it accepts a new level only after that level has been stable long enough. As an immediate filter it passes the first edge at once and then shuts out chatter for a programmed time.

Each cell drives a conditioned level and two strobes, one for rising and one for falling, each lasting one module clock and coinciding with the change of the level. Configuration comes in as plain static levels, one field per cell packed into wide vectors, and is meant to be changed only while reset is held. The outputs are continuous levels that are not consumed by anyone, so there is no valid/ready handshake and no back-pressure. A downstream user samples the level or the strobes on any clock.

Top module: `fpc_array`

## Requirements
- R1: Each cell's 2-bit mode field selects 0 = prescaler, 1 = delayed filter, 2 = immediate filter. Code 3 behaves exactly as code 1.
- R2: The source field of cell n selects: codes 0..NUM_PORTS-1 pick that port line, code NUM_PORTS picks an internal signal that toggles on every module clock, and code NUM_PORTS+1 picks the output of cell n-1 (cell 0 reads a constant 0 there). Any higher code reads 0.
- R3: The enable field selects code 0 = every module clock, codes 1..NUM_EN = clk_en_in[code-1], and any higher code = every module clock. A cell samples its input and advances its state only on a cycle whose selected enable is high.
- R4: Every port line passes through two flip-flops before use. In delayed mode with limit 1 and enable every cycle, a port change driven before clock edge k shows on the cell output after edge k+2.
- R5: Delayed filter: a sample that differs from the output increments a counter. When the count of consecutive differing samples reaches the limit (a limit of 0 counts as 1), the output inverts and the counter clears. A sample equal to the output clears the counter.
- R6: Immediate filter: while idle, a sample that differs from the output inverts the output at once and starts a hold. During the hold, input changes are ignored. The hold ends on the limit-th enabled tick after the inversion (a limit of 0 counts as 1), and sampling resumes on the next tick.
- R7: Prescaler: each qualifying input edge increments a counter. The edge that brings the count to the limit (a limit of 0 counts as 1) drives the output high for that cycle and clears the counter. Otherwise the output is 0.
- R8: In prescaler mode, bit 0 of the 2-bit edge field qualifies rising edges and bit 1 qualifies falling edges. Edges are found between consecutive enabled samples.
- R9: cell_rise and cell_fall pulse high for one cycle in exactly the cycle in which cell_out becomes 1 or 0 respectively.
- R10: While rst_n is low, all outputs, strobes, counters and synchroniser stages are 0.
- R11: A cell fed from its neighbour sees that neighbour's output with no synchroniser, so in delayed mode with limit 1 it follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_in | input | NUM_PORTS | Asynchronous external lines |
| clk_en_in | input | NUM_EN | Selectable counting enables |
| cfg_mode | input | 2*NUM_CELLS | Mode field per cell |
| cfg_edge | input | 2*NUM_CELLS | Prescaler edge qualifier per cell |
| cfg_src | input | SRC_W*NUM_CELLS | Input source field per cell |
| cfg_clksel | input | CKS_W*NUM_CELLS | Enable select field per cell |
| cfg_limit | input | CNT_W*NUM_CELLS | Count limit per cell |
| cell_out | output | NUM_CELLS | Conditioned level per cell |
| cell_rise | output | NUM_CELLS | Rising strobe per cell |
| cell_fall | output | NUM_CELLS | Falling strobe per cell |

## Verification
The properties assume that the configuration vectors stay fixed outside reset, so a mode, limit or enable choice seen in one cycle is still in force in the next. The bench respects this by writing every field while rst_n is low and releasing reset only afterwards. Single-cycle separation between transitions is claimed only for limits of 2 or more, because smaller limits legally allow back-to-back changes. The stimulus covers both regimes, and the checks for small limits are left to the bench's own cycle model.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    MODE_PRESC  = 2'd0,
    MODE_DELAY  = 2'd1,
    MODE_IMMED  = 2'd2,
    MODE_DELAY2 = 2'd3
  } fpc_mode_e;

  localparam int EDGE_RISE_BIT = 0;
  localparam int EDGE_FALL_BIT = 1;
endpackage

// File: rtl/fpc_sync.sv
module fpc_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/fpc_src_mux.sv
module fpc_src_mux #(
  parameter int NUM_PORTS = 4,
  parameter int NUM_EN    = 4,
  parameter int SRC_W     = 3,
  parameter int CKS_W     = 3
) (
  input  logic [NUM_PORTS-1:0] port_sync,
  input  logic                 mclk_src,
  input  logic                 cascade_in,
  input  logic [NUM_EN-1:0]    en_vec,
  input  logic [SRC_W-1:0]     src_sel,
  input  logic [CKS_W-1:0]     ck_sel,
  output logic                 din,
  output logic                 tick
);
  localparam logic [SRC_W-1:0] SEL_MCLK = SRC_W'(NUM_PORTS);
  localparam logic [SRC_W-1:0] SEL_CASC = SRC_W'(NUM_PORTS + 1);

  always_comb begin
    din = 1'b0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      if (src_sel == SRC_W'(k)) din = port_sync[k];
    end
    if (src_sel == SEL_MCLK) din = mclk_src;
    if (src_sel == SEL_CASC) din = cascade_in;
  end

  always_comb begin
    tick = 1'b1;
    for (int k = 0; k < NUM_EN; k++) begin
      if (ck_sel == CKS_W'(k + 1)) tick = en_vec[k];
    end
  end
endmodule

// File: rtl/fpc_cell.sv
module fpc_cell
  import fpc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [1:0]       edge_sel,
  input  logic [CNT_W-1:0] limit,
  input  logic             din,
  input  logic             tick,
  output logic             out_lvl,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic             din_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;
  logic             hold_q, hold_d;
  logic             rise_q, fall_q;
  logic [CNT_W:0]   cnt_inc;
  logic             reached;
  logic             edge_hit;
  fpc_mode_e        mode_e;

  assign mode_e  = fpc_mode_e'(mode);
  assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign reached = cnt_inc >= {1'b0, limit};

  always_comb begin
    edge_hit = tick & ((edge_sel[EDGE_RISE_BIT] & din & ~din_q) |
                       (edge_sel[EDGE_FALL_BIT] & ~din & din_q));
  end

  always_comb begin
    out_d  = out_q;
    cnt_d  = cnt_q;
    hold_d = hold_q;
    case (mode_e)
      MODE_PRESC: begin
        out_d  = 1'b0;
        hold_d = 1'b0;
        if (edge_hit) begin
          if (reached) begin
            out_d = 1'b1;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_inc[CNT_W-1:0];
          end
        end
      end
      MODE_IMMED: begin
        if (tick) begin
          if (hold_q) begin
            if (reached) begin
              hold_d = 1'b0;
              cnt_d  = '0;
            end else begin
              cnt_d = cnt_inc[CNT_W-1:0];
            end
          end else if (din != out_q) begin
            out_d  = ~out_q;
            hold_d = 1'b1;
            cnt_d  = '0;
          end
        end
      end
      default: begin
        hold_d = 1'b0;
        if (tick) begin
          if (din != out_q) begin
            if (reached) begin
              out_d = ~out_q;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_inc[CNT_W-1:0];
            end
          end else begin
            cnt_d = '0;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      din_q  <= 1'b0;
      cnt_q  <= '0;
      out_q  <= 1'b0;
      hold_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      if (tick) din_q <= din;
      cnt_q  <= cnt_d;
      out_q  <= out_d;
      hold_q <= hold_d;
      rise_q <= out_d & ~out_q;
      fall_q <= ~out_d & out_q;
    end
  end

  assign out_lvl  = out_q;
  assign rise_stb = rise_q;
  assign fall_stb = fall_q;
endmodule

// File: rtl/fpc_array.sv
module fpc_array #(
  parameter int NUM_CELLS = 6,
  parameter int NUM_PORTS = 4,
  parameter int NUM_EN    = 4,
  parameter int CNT_W     = 16,
  parameter int SRC_W     = $clog2(NUM_PORTS + 2),
  parameter int CKS_W     = $clog2(NUM_EN + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PORTS-1:0]       port_in,
  input  logic [NUM_EN-1:0]          clk_en_in,
  input  logic [2*NUM_CELLS-1:0]     cfg_mode,
  input  logic [2*NUM_CELLS-1:0]     cfg_edge,
  input  logic [SRC_W*NUM_CELLS-1:0] cfg_src,
  input  logic [CKS_W*NUM_CELLS-1:0] cfg_clksel,
  input  logic [CNT_W*NUM_CELLS-1:0] cfg_limit,
  output logic [NUM_CELLS-1:0]       cell_out,
  output logic [NUM_CELLS-1:0]       cell_rise,
  output logic [NUM_CELLS-1:0]       cell_fall
);
  logic [NUM_PORTS-1:0] port_sync;
  logic                 mclk_tgl_q;

  fpc_sync #(.WIDTH(NUM_PORTS)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(port_in),
    .sync_out(port_sync)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) mclk_tgl_q <= 1'b0;
    else        mclk_tgl_q <= ~mclk_tgl_q;
  end

  for (genvar n = 0; n < NUM_CELLS; n++) begin : g_cell
    logic casc;
    logic din;
    logic tick;

    if (n == 0) begin : g_head
      assign casc = 1'b0;
    end else begin : g_link
      assign casc = cell_out[n-1];
    end

    fpc_src_mux #(
      .NUM_PORTS(NUM_PORTS),
      .NUM_EN   (NUM_EN),
      .SRC_W    (SRC_W),
      .CKS_W    (CKS_W)
    ) mux_i (
      .port_sync (port_sync),
      .mclk_src  (mclk_tgl_q),
      .cascade_in(casc),
      .en_vec    (clk_en_in),
      .src_sel   (cfg_src[n*SRC_W +: SRC_W]),
      .ck_sel    (cfg_clksel[n*CKS_W +: CKS_W]),
      .din       (din),
      .tick      (tick)
    );

    fpc_cell #(.CNT_W(CNT_W)) cell_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (cfg_mode[n*2 +: 2]),
      .edge_sel(cfg_edge[n*2 +: 2]),
      .limit   (cfg_limit[n*CNT_W +: CNT_W]),
      .din     (din),
      .tick    (tick),
      .out_lvl (cell_out[n]),
      .rise_stb(cell_rise[n]),
      .fall_stb(cell_fall[n])
    );
  end
endmodule

// File: rtl/fpc_array_chk.sv
module fpc_array_chk #(
  parameter int NUM_CELLS = 6,
  parameter int NUM_EN    = 4,
  parameter int CNT_W     = 16,
  parameter int CKS_W     = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_EN-1:0]          clk_en_in,
  input logic [2*NUM_CELLS-1:0]     cfg_mode,
  input logic [CKS_W*NUM_CELLS-1:0] cfg_clksel,
  input logic [CNT_W*NUM_CELLS-1:0] cfg_limit,
  input logic [NUM_CELLS-1:0]       cell_out,
  input logic [NUM_CELLS-1:0]       cell_rise,
  input logic [NUM_CELLS-1:0]       cell_fall
);
  for (genvar n = 0; n < NUM_CELLS; n++) begin : g_chk
    logic [1:0]       md;
    logic [CNT_W-1:0] lim;
    logic [CKS_W-1:0] cks;
    assign md  = cfg_mode[n*2 +: 2];
    assign lim = cfg_limit[n*CNT_W +: CNT_W];
    assign cks = cfg_clksel[n*CKS_W +: CKS_W];

    p_rise_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cell_rise[n] |-> (cell_out[n] && !$past(cell_out[n])));

    p_fall_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cell_fall[n] |-> (!cell_out[n] && $past(cell_out[n])));

    p_presc_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (md == 2'd0 && lim >= CNT_W'(2) && cell_out[n]) |=> !cell_out[n]);

    p_filter_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (md != 2'd0 && lim >= CNT_W'(2) && (cell_rise[n] || cell_fall[n]))
      |=> !(cell_rise[n] || cell_fall[n]));

    p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (md != 2'd0 && cks == CKS_W'(1) && !clk_en_in[0]) |=> $stable(cell_out[n]));
  end
endmodule

bind fpc_array fpc_array_chk #(
  .NUM_CELLS(NUM_CELLS),
  .NUM_EN   (NUM_EN),
  .CNT_W    (CNT_W),
  .CKS_W    (CKS_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_en_in (clk_en_in),
  .cfg_mode  (cfg_mode),
  .cfg_clksel(cfg_clksel),
  .cfg_limit (cfg_limit),
  .cell_out  (cell_out),
  .cell_rise (cell_rise),
  .cell_fall (cell_fall)
);

// File: tb/fpc_array_tb_top.sv
`timescale 1ns/1ps
module fpc_array_tb_top;
  localparam int NC = 6;
  localparam int NP = 4;
  localparam int NE = 4;
  localparam int CW = 16;
  localparam int SW = 3;
  localparam int KW = 3;
  localparam int NVEC = 10;

  // entry: [51:50] mode, [49:48] edge, [47:32] limit, [31:0] stimulus bits (LSB first)
  localparam logic [51:0] VEC [NVEC] = '{
    {2'd1, 2'd0, 16'd3, 32'h00FF_3C05},
    {2'd1, 2'd0, 16'd1, 32'hA5A5_F00F},
    {2'd1, 2'd0, 16'd0, 32'h1234_5678},
    {2'd2, 2'd0, 16'd4, 32'h0F0F_A5A5},
    {2'd2, 2'd0, 16'd1, 32'hFF00_33CC},
    {2'd0, 2'd3, 16'd3, 32'hAAAA_5555},
    {2'd0, 2'd1, 16'd2, 32'hCCCC_CCCC},
    {2'd0, 2'd2, 16'd1, 32'hF0F0_0F0F},
    {2'd3, 2'd0, 16'd2, 32'h0E0E_6666},
    {2'd0, 2'd3, 16'd0, 32'h3333_0F0F}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]    port_in = '0;
  logic [NE-1:0]    clk_en_in = '0;
  logic [2*NC-1:0]  cfg_mode = '0;
  logic [2*NC-1:0]  cfg_edge = '0;
  logic [SW*NC-1:0] cfg_src = '0;
  logic [KW*NC-1:0] cfg_clksel = '0;
  logic [CW*NC-1:0] cfg_limit = '0;
  logic [NC-1:0]    cell_out, cell_rise, cell_fall;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference state for cell 0
  logic m_out, m_prev, m_hold, m_rise, m_fall;
  int   m_cnt;

  always #2 clk = ~clk;

  fpc_array dut_i (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .clk_en_in(clk_en_in),
    .cfg_mode(cfg_mode), .cfg_edge(cfg_edge), .cfg_src(cfg_src),
    .cfg_clksel(cfg_clksel), .cfg_limit(cfg_limit),
    .cell_out(cell_out), .cell_rise(cell_rise), .cell_fall(cell_fall)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cell(input int n, input int md, input int ed, input int lim,
                          input int src, input int cks);
    cfg_mode[n*2 +: 2]    = 2'(md);
    cfg_edge[n*2 +: 2]    = 2'(ed);
    cfg_limit[n*CW +: CW] = CW'(lim);
    cfg_src[n*SW +: SW]   = SW'(src);
    cfg_clksel[n*KW +: KW] = KW'(cks);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    port_in = '0;
    clk_en_in = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
  endtask

  // one enabled tick of the requirement model (R5, R6, R7, R8)
  task automatic model_step(input int md, input int ed, input int lim, input logic in);
    logic old;
    int   lm;
    bit   hit;
    lm  = (lim == 0) ? 1 : lim;
    old = m_out;
    case (md)
      0: begin
        hit = (ed[0] && in && !m_prev) || (ed[1] && !in && m_prev);
        m_out = 1'b0;
        if (hit) begin
          m_cnt++;
          if (m_cnt >= lm) begin m_out = 1'b1; m_cnt = 0; end
        end
      end
      2: begin
        if (m_hold) begin
          m_cnt++;
          if (m_cnt >= lm) begin m_hold = 1'b0; m_cnt = 0; end
        end else if (in != m_out) begin
          m_out = ~m_out; m_hold = 1'b1; m_cnt = 0;
        end
      end
      default: begin
        if (in != m_out) begin
          m_cnt++;
          if (m_cnt >= lm) begin m_out = ~m_out; m_cnt = 0; end
        end else m_cnt = 0;
      end
    endcase
    m_prev = in;
    m_rise = m_out & ~old;
    m_fall = ~m_out & old;
  endtask

  function automatic string req_of(input int md);
    if (md == 0) return "R7_R8";
    if (md == 2) return "R6";
    if (md == 3) return "R1";
    return "R5";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R10 act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    do_reset();
    chk("R10 out", int'(cell_out), 0);
    chk("R10 rise", int'(cell_rise), 0);
    chk("R10 fall", int'(cell_fall), 0);

    // table walk on cell 0, port 0, enable every cycle
    for (int v = 0; v < NVEC; v++) begin
      int md, ed, lim;
      logic [31:0] pat;
      logic d1, d2, cin;
      md  = int'(VEC[v][51:50]);
      ed  = int'(VEC[v][49:48]);
      lim = int'(VEC[v][47:32]);
      pat = VEC[v][31:0];
      do_reset();
      set_cell(0, md, ed, lim, 0, 0);
      m_out = 0; m_prev = 0; m_hold = 0; m_cnt = 0; m_rise = 0; m_fall = 0;
      d1 = 0; d2 = 0;
      release_reset();
      for (int i = 0; i < 36; i++) begin
        port_in[0] = (i < 32) ? pat[i] : 1'b0;
        @(posedge clk);
        @(negedge clk);
        cin = d2;          // R4: two synchroniser stages
        d2 = d1;
        d1 = port_in[0];
        model_step(md, ed, lim, cin);
        chk($sformatf("%s out v%0d c%0d", req_of(md), v, i), int'(cell_out[0]), int'(m_out));
        chk($sformatf("R9 rise v%0d c%0d", v, i), int'(cell_rise[0]), int'(m_rise));
        chk($sformatf("R9 fall v%0d c%0d", v, i), int'(cell_fall[0]), int'(m_fall));
      end
    end

    // R4: port to output latency, delayed mode limit 1
    do_reset();
    set_cell(0, 1, 0, 1, 0, 0);
    release_reset();
    repeat (4) @(negedge clk);
    port_in[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R4 not yet after 2 edges", int'(cell_out[0]), 0);
    @(negedge clk);
    chk("R4 out after 3 edges", int'(cell_out[0]), 1);
    chk("R9 rise with R4 change", int'(cell_rise[0]), 1);

    // R3: selected enable gates the filter
    do_reset();
    set_cell(0, 1, 0, 1, 0, 1);
    release_reset();
    port_in[0] = 1'b1;
    repeat (6) @(negedge clk);
    chk("R3 no tick no change", int'(cell_out[0]), 0);
    clk_en_in[0] = 1'b1;
    @(negedge clk);
    clk_en_in[0] = 1'b0;
    chk("R3 single tick flips", int'(cell_out[0]), 1);

    // R2: port select and R11 cascade
    do_reset();
    set_cell(0, 1, 0, 1, 0, 0);
    set_cell(1, 1, 0, 1, NP + 1, 0);
    set_cell(3, 1, 0, 1, 2, 0);
    release_reset();
    repeat (3) @(negedge clk);
    port_in[2] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 port 2 reaches cell 3", int'(cell_out[3]), 1);
    chk("R2 port 0 cell unaffected", int'(cell_out[0]), 0);
    port_in[0] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 cell 0 high", int'(cell_out[0]), 1);
    chk("R11 cell 1 still low", int'(cell_out[1]), 0);
    @(negedge clk);
    chk("R11 cell 1 follows", int'(cell_out[1]), 1);
    chk("R11 cell 1 rise", int'(cell_rise[1]), 1);

    // R2: module clock source, prescaler both edges, limit 4
    do_reset();
    set_cell(2, 0, 3, 4, NP, 0);
    release_reset();
    repeat (8) @(negedge clk);
    begin
      int pulses = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (cell_rise[2]) pulses++;
      end
      chk("R2 R7 module clock pulses", pulses, 10);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule